// File: doc/BRIEF.md
# Receive Buffer Address Queue

This block manages the receive buffers of a fast Ethernet MAC. Software hands the block free buffer addresses, one per register write, and the block keeps them in a hardware ring. When the receive engine reports a finished frame (a one-cycle strobe with the frame length), the block takes the oldest free buffer and files a descriptor: the frame length, the ring slot the buffer occupied and the buffer address. Software reads the head descriptor, consumes the frame and retires the descriptor by a write-one to the receive-ready bit. It then recycles the buffer by pushing its address again.

Receive interrupts are coalesced. A sticky flag raises the interrupt output when the number of pending descriptors reaches a programmable count, or when a programmable cycle timer runs out while at least one descriptor waits. A frame that finds no free buffer is dropped and counted. The frame data path and memory writes are outside the block.

Top module: `rxbuf_queue`

## Requirements
- R1: A write to word address 1 appends one free buffer address to the ring only while the free count is below the configured receive depth; otherwise the write is ignored. Word address 6 reads the free count in bits 6:0, the pending descriptor count in bits 14:8 and receive-ready in bit 25.
- R2: Word address 5 holds the receive depth in bits 13:8 (reset value 63, all other bits read 0); lowering it caps the number of free addresses accepted.
- R3: A frame strobe with a free buffer available takes the oldest free buffer and queues a descriptor. Word address 2 reads the head descriptor with the length in bits 11:0 and the ring slot in bits 17:12; word address 3 reads its buffer address. Slots are ring positions handed out 0, 1, 2, ... in push order, wrapping after 63. Both read 0 with no descriptor pending.
- R4: A frame strobe when the free count (as it stood before that cycle) is zero is dropped: no descriptor is queued and the drop counter at word address 7 increments. A push in the same cycle does not rescue the frame.
- R5: Bit 0 of word address 0 reads 1 while any descriptor is pending; writing 1 to bit 0 retires the head descriptor.
- R6: Bit 7 of word address 0 sets one cycle after the pending count reaches the threshold held in bits 31:24 of word address 4 (reset value 8).
- R7: With descriptors pending, bit 7 sets L+1 cycles after the pending count leaves zero or after the previous firing, where L is bits 15:0 of word address 4 (reset value 0x74); the timer restarts on every firing and whenever nothing is pending.
- R8: Bit 7 is cleared by writing 1 to it; a firing in the same cycle wins over the clear. The irq output equals bit 7.
- R9: A frame strobe in the same cycle as a push or as a descriptor retire performs both operations.
- R10: After reset every register reads 0 except word address 4 (0x0800_0074) and word address 5 (0x0000_3F00), and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| frm_done | input | 1 | One-cycle strobe: a frame has been received |
| frm_len | input | 12 | Length of the frame reported by frm_done |
| irq | output | 1 | Coalesced receive interrupt |

## Verification
The two functions that collide are frame arrival and software queue traffic: a frame strobe can land in the same cycle as a free-address push or as a descriptor retire. The bench drives both strobes together in one cycle, once with the free ring empty (the frame must be dropped and the address still kept), once with one free entry (buffer taken and new address appended, free count unchanged) and once with one descriptor pending (new descriptor queued while the old one retires, so the head advances by one slot). Each outcome is judged through the status, descriptor and drop registers read right after that cycle; a coalescing clear issued while the threshold still holds is judged by irq staying high.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int SLOT_W = 6;

  localparam int DESC_SLOT_LSB = 12;
  localparam int COAL_THR_LSB  = 24;
  localparam int QCFG_DEP_LSB  = 8;
  localparam int QSTAT_PND_LSB = 8;
  localparam int QSTAT_RDY_BIT = 25;
  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_COAL_BIT = 7;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_PUSH  = 3'd1,
    REG_DESC  = 3'd2,
    REG_DADDR = 3'd3,
    REG_COAL  = 3'd4,
    REG_QCFG  = 3'd5,
    REG_QSTAT = 3'd6,
    REG_DROPS = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  len;
  } rx_desc_t;

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic [IW-1:0] rd_idx
);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    rd_n    = rd_q;
    wr_n    = wr_q;
    if (do_push) wr_n = step(wr_q);
    if (do_pop)  rd_n = step(rd_q);
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout   = mem[rd_q];
  assign count  = cnt_q;
  assign rd_idx = rd_q;

  // R1: the owner never pushes into a full ring
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));

  // R5: the owner never pops an empty ring
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  // R3: a lone push raises the occupancy by exactly one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && (cnt_q != CW'(DEPTH))) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rxq_coal.sv
module rxq_coal #(
  parameter int CW    = 7,
  parameter int THR_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    pend,
  input  logic [THR_W-1:0] thr,
  input  logic [TMR_W-1:0] lim,
  input  logic             clr,
  output logic             flag
);

  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic             flag_q, flag_n;
  logic             busy, hit_cnt, hit_tmr, fire;

  always_comb begin
    busy    = (pend != '0);
    hit_cnt = (32'(pend) >= 32'(thr));
    hit_tmr = (tmr_q >= lim);
    fire    = busy && (hit_cnt || hit_tmr);
    tmr_n   = tmr_q;
    if (fire || !busy)      tmr_n = '0;
    else if (tmr_q != '1)   tmr_n = tmr_q + 1'b1;
    flag_n = flag_q;
    if (clr)  flag_n = 1'b0;
    if (fire) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_n;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

  // R7: nothing pending means the timer starts over
  assert_timer_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (tmr_q == '0));

  // R7: an expired timer with work pending raises the flag and restarts
  assert_timer_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend != '0) && (tmr_q >= lim)) |=> (flag_q && (tmr_q == '0)));

  // R8: the flag only drops on an explicit clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/rxbuf_queue.sv
module rxbuf_queue
  import rxq_pkg::*;
#(
  parameter int QDEPTH  = 64,
  parameter int TMR_W   = 16,
  parameter int THR_W   = 8,
  parameter int DROP_W  = 16,
  parameter int DEF_THR = 8,
  parameter int DEF_TMR = 116
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              irq
);

  localparam int IW = $clog2(QDEPTH);
  localparam int CW = IW + 1;
  localparam int DW = $bits(rx_desc_t);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  reg_sel_e           sel;
  logic [THR_W-1:0]   thr_q, thr_n;
  logic [TMR_W-1:0]   lim_q, lim_n;
  logic [SLOT_W-1:0]  dep_q, dep_n;
  logic [DROP_W-1:0]  drop_q, drop_n;

  logic [ADDR_W-1:0]  fr_dout;
  logic [CW-1:0]      fr_cnt;
  logic [IW-1:0]      fr_idx;
  logic [DW-1:0]      dq_raw;
  rx_desc_t           dq_head, dq_new;
  logic [CW-1:0]      dq_cnt;
  logic [IW-1:0]      dq_idx;

  logic push_req, push_ok, take, drop, pop_desc, clr_flag, coal_flag, rdy;

  // request decode
  always_comb begin
    sel      = reg_sel_e'(reg_addr);
    push_req = reg_wr && (sel == REG_PUSH);
    push_ok  = push_req && ({1'b0, dep_q} > fr_cnt);
    take     = frm_done && (fr_cnt != '0) && (dq_cnt != CW'(QDEPTH));
    drop     = frm_done && !take;
    rdy      = (dq_cnt != '0);
    pop_desc = reg_wr && (sel == REG_STAT) && reg_wdata[STAT_RDY_BIT] && rdy;
    clr_flag = reg_wr && (sel == REG_STAT) && reg_wdata[STAT_COAL_BIT];
    dq_new.addr = fr_dout;
    dq_new.slot = SLOT_W'(fr_idx);
    dq_new.len  = frm_len;
    dq_head     = rx_desc_t'(dq_raw);
  end

  // configuration and drop counter, next state
  always_comb begin
    thr_n  = thr_q;
    lim_n  = lim_q;
    dep_n  = dep_q;
    drop_n = drop_q;
    if (reg_wr && (sel == REG_COAL)) begin
      thr_n = reg_wdata[COAL_THR_LSB +: THR_W];
      lim_n = reg_wdata[TMR_W-1:0];
    end
    if (reg_wr && (sel == REG_QCFG)) dep_n = reg_wdata[QCFG_DEP_LSB +: SLOT_W];
    if (drop) drop_n = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      thr_q  <= THR_W'(DEF_THR);
      lim_q  <= TMR_W'(DEF_TMR);
      dep_q  <= '1;
      drop_q <= '0;
    end else begin
      thr_q  <= thr_n;
      lim_q  <= lim_n;
      dep_q  <= dep_n;
      drop_q <= drop_n;
    end
  end

  rxq_ring #(.W(ADDR_W), .DEPTH(QDEPTH)) u_free (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .push   (push_ok),
    .pop    (take),
    .din    (reg_wdata),
    .dout   (fr_dout),
    .count  (fr_cnt),
    .rd_idx (fr_idx)
  );

  rxq_ring #(.W(DW), .DEPTH(QDEPTH)) u_done (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .push   (take),
    .pop    (pop_desc),
    .din    (DW'(dq_new)),
    .dout   (dq_raw),
    .count  (dq_cnt),
    .rd_idx (dq_idx)
  );

  rxq_coal #(.CW(CW), .THR_W(THR_W), .TMR_W(TMR_W)) u_coal (
    .clk   (clk),
    .rst_n (rst_i_n),
    .pend  (dq_cnt),
    .thr   (thr_q),
    .lim   (lim_q),
    .clr   (clr_flag),
    .flag  (coal_flag)
  );

  assign irq = coal_flag;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (sel)
      REG_STAT:  reg_rdata = (32'(rdy) << STAT_RDY_BIT) | (32'(coal_flag) << STAT_COAL_BIT);
      REG_DESC:  if (rdy) reg_rdata = (32'(dq_head.slot) << DESC_SLOT_LSB) | 32'(dq_head.len);
      REG_DADDR: if (rdy) reg_rdata = 32'(dq_head.addr);
      REG_COAL:  reg_rdata = (32'(thr_q) << COAL_THR_LSB) | 32'(lim_q);
      REG_QCFG:  reg_rdata = 32'(dep_q) << QCFG_DEP_LSB;
      REG_QSTAT: reg_rdata = (32'(rdy) << QSTAT_RDY_BIT) | (32'(dq_cnt) << QSTAT_PND_LSB)
                             | 32'(fr_cnt);
      REG_DROPS: reg_rdata = 32'(drop_q);
      default:   reg_rdata = '0;
    endcase
  end

  // R4: a frame with no free buffer is counted as dropped
  assert_drop_count_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (frm_done && (fr_cnt == '0)) |=> (drop_q == $past(drop_q) + 1'b1));

  // R3: an accepted frame leaves a descriptor pending
  assert_take_records_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    take |=> (dq_cnt != '0));

  // R3: retiring a descriptor moves the head to the next ring slot
  assert_desc_order_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    pop_desc |=> (dq_idx == IW'($past(dq_idx) + 1'b1)));

  // R1, R2: a push beyond the configured depth leaves the free count alone
  assert_depth_cap_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (push_req && ({1'b0, dep_q} <= fr_cnt) && !take) |=> (fr_cnt == $past(fr_cnt)));

endmodule

// File: tb/sim_rxbuf_queue.sv
module sim_rxbuf_queue;

  localparam logic [2:0] A_STAT = 3'd0, A_PUSH = 3'd1, A_DESC = 3'd2, A_DADDR = 3'd3,
                         A_COAL = 3'd4, A_QCFG = 3'd5, A_QSTAT = 3'd6, A_DROPS = 3'd7;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_FRM = 2'd2;
  localparam int NVEC = 24;

  // {op, addr, data, expected, requirement number}
  localparam logic [72:0] VEC [NVEC] = '{
    {OP_WR,  A_PUSH,  32'h0000_1000, 32'h0,           4'd1},
    {OP_WR,  A_PUSH,  32'h0000_2000, 32'h0,           4'd1},
    {OP_WR,  A_PUSH,  32'h0000_3000, 32'h0,           4'd1},
    {OP_RD,  A_QSTAT, 32'h0,         32'h0000_0003,   4'd1},
    {OP_FRM, 3'd0,    32'd60,        32'h0,           4'd3},
    {OP_RD,  A_STAT,  32'h0,         32'h0000_0001,   4'd5},
    {OP_RD,  A_DESC,  32'h0,         32'h0000_003C,   4'd3},
    {OP_RD,  A_DADDR, 32'h0,         32'h0000_1000,   4'd3},
    {OP_RD,  A_QSTAT, 32'h0,         32'h0200_0102,   4'd5},
    {OP_WR,  A_STAT,  32'h1,         32'h0,           4'd5},
    {OP_RD,  A_STAT,  32'h0,         32'h0000_0000,   4'd5},
    {OP_FRM, 3'd0,    32'h5EA,       32'h0,           4'd3},
    {OP_RD,  A_DESC,  32'h0,         32'h0000_15EA,   4'd3},
    {OP_RD,  A_DADDR, 32'h0,         32'h0000_2000,   4'd3},
    {OP_WR,  A_STAT,  32'h1,         32'h0,           4'd5},
    {OP_FRM, 3'd0,    32'hFFF,       32'h0,           4'd3},
    {OP_RD,  A_DESC,  32'h0,         32'h0000_2FFF,   4'd3},
    {OP_WR,  A_STAT,  32'h1,         32'h0,           4'd5},
    {OP_WR,  A_PUSH,  32'h0000_4000, 32'h0,           4'd1},
    {OP_FRM, 3'd0,    32'd100,       32'h0,           4'd3},
    {OP_RD,  A_DESC,  32'h0,         32'h0000_3064,   4'd3},
    {OP_RD,  A_DADDR, 32'h0,         32'h0000_4000,   4'd3},
    {OP_WR,  A_STAT,  32'h1,         32'h0,           4'd5},
    {OP_RD,  A_QSTAT, 32'h0,         32'h0000_0000,   4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n, reg_wr, frm_done, irq;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [11:0] frm_len;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rxbuf_queue u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .frm_done  (frm_done),
    .frm_len   (frm_len),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic frm(input logic [11:0] l);
    @(negedge clk);
    frm_done = 1'b1; frm_len = l;
    @(posedge clk);
    #1 frm_done = 1'b0;
  endtask

  task automatic wr_frm(input logic [2:0] a, input logic [31:0] d, input logic [11:0] l);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    frm_done = 1'b1; frm_len = l;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; frm_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    frm_done = 1'b0; frm_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: reset state
    @(negedge clk);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_STAT,  32'h0,         "R10 status reset");
    rd(A_QSTAT, 32'h0,         "R10 queue status reset");
    rd(A_DROPS, 32'h0,         "R10 drops reset");
    rd(A_COAL,  32'h0800_0074, "R10 coalescing reset");
    rd(A_QCFG,  32'h0000_3F00, "R10 depth reset");

    // vector table: pushes, frames, descriptor reads and retires
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op;
      logic [2:0]  ra;
      logic [31:0] d, e;
      logic [3:0]  rq;
      {op, ra, d, e, rq} = VEC[i];
      case (op)
        OP_WR:   wr(ra, d);
        OP_FRM:  frm(d[11:0]);
        default: rd(ra, e, $sformatf("R%0d vector %0d", rq, i));
      endcase
    end

    // R4: frame with an empty free ring is dropped
    frm(12'd50);
    rd(A_DROPS, 32'h1, "R4 drop counted");
    rd(A_STAT,  32'h0, "R4 no descriptor for dropped frame");

    // R2: depth cap (pushes land in slots 4 and 5, third ignored)
    wr(A_QCFG, 32'h0000_0200);
    rd(A_QCFG, 32'h0000_0200, "R2 depth readback");
    wr(A_PUSH, 32'h0000_A000);
    wr(A_PUSH, 32'h0000_B000);
    wr(A_PUSH, 32'h0000_C000);
    rd(A_QSTAT, 32'h0000_0002, "R2 free count capped");
    wr(A_QCFG, 32'h0000_3F00);

    // R6: count threshold 3, timer out of reach
    wr(A_COAL, 32'h0300_FFFF);
    rd(A_COAL, 32'h0300_FFFF, "R6 coalescing readback");
    wr(A_PUSH, 32'h0000_D000);
    frm(12'd10);
    frm(12'd11);
    frm(12'd12);
    chk("R6 irq not yet at threshold edge", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R6 irq one cycle after threshold", {31'b0, irq}, 32'h1);
    rd(A_STAT,  32'h0000_0081, "R6 status bits");
    rd(A_DESC,  32'h0000_400A, "R3 head slot 4");
    rd(A_DADDR, 32'h0000_A000, "R3 head address");
    wr(A_STAT, 32'h80);
    chk("R8 set wins over clear", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    wr(A_STAT, 32'h80);
    chk("R8 clear below threshold", {31'b0, irq}, 32'h0);
    rd(A_STAT, 32'h1, "R8 ready kept after clear");
    wr(A_STAT, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, 32'h0, "R5 all retired");

    // R7: timer limit 5
    wr(A_COAL, 32'h0800_0005);
    wr(A_PUSH, 32'h0000_E000);
    frm(12'd20);
    repeat (5) @(posedge clk);
    #1 chk("R7 irq low at limit", {31'b0, irq}, 32'h0);
    @(posedge clk);
    #1 chk("R7 irq high at limit plus one", {31'b0, irq}, 32'h1);
    rd(A_DESC, 32'h0000_7014, "R3 slot 7 descriptor");
    wr(A_STAT, 32'h81);
    chk("R8 irq cleared with retire", {31'b0, irq}, 32'h0);
    rd(A_STAT, 32'h0, "R7 nothing pending");
    wr(A_COAL, 32'h0800_0074);

    // R9: same-cycle collisions
    wr_frm(A_PUSH, 32'h0000_5000, 12'd64);
    rd(A_DROPS, 32'h2,         "R4 push same cycle does not rescue frame");
    rd(A_QSTAT, 32'h0000_0001, "R9 address kept despite drop");
    wr_frm(A_PUSH, 32'h0000_6000, 12'd200);
    rd(A_QSTAT, 32'h0200_0101, "R9 take and push together");
    rd(A_DESC,  32'h0000_80C8, "R9 descriptor slot 8");
    rd(A_DADDR, 32'h0000_5000, "R9 address slot 8");
    wr_frm(A_STAT, 32'h1, 12'd300);
    rd(A_QSTAT, 32'h0200_0100, "R9 take and retire together");
    rd(A_DESC,  32'h0000_912C, "R9 descriptor slot 9");
    rd(A_DADDR, 32'h0000_6000, "R9 address slot 9");
    wr(A_STAT, 32'h1);
    rd(A_QSTAT, 32'h0, "R5 empty at end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule